// File: doc/BRIEF.md
# AHB-Lite Slave with Two-Cycle Error Response

This block is the bus-facing front end of a small register file on an AHB-Lite bus. It takes each transfer in its address phase, decides in that same cycle whether the access is legal, and completes the data phase one cycle later. A legal read or write finishes with no wait states and an OKAY response. An access outside the decoded address window, or a write that lands in the read-only part of that window, is answered with the two-cycle ERROR sequence. In the first cycle the ready output is low and the response is ERROR. In the second cycle the ready output is high and the response is still ERROR.

The slave follows bursts itself. The direction, size and burst type are captured on the NONSEQ beat and held for the SEQ beats that follow. It counts the beats of fixed-length bursts. It drops a burst as soon as an IDLE or NONSEQ beat appears, or as soon as the bus moves to another slave. Once a burst has drawn an ERROR, the SEQ beats the master still issues for that burst get OKAY and touch nothing. The next NONSEQ starts a fresh burst. The ready output is the only back-pressure. While it is low, the master must hold its address-phase signals, and no new data phase starts. The ready output is low only in the first cycle of an ERROR. This is a single-slave attachment, so the ready output also serves as the bus ready seen by the slave.

Top module: `ahb_err_slave`

## Requirements
- R1: During reset and right after it, `ready_o` is 1, `resp_o` is 0 (OKAY) and every storage word reads 0. Asserting reset in the middle of an ERROR returns the outputs to this state at once.
- R2: A valid beat (`sel_i`=1, `trans_i` = 2'b10 NONSEQ or 2'b11 SEQ) whose address is below `WIN_BASE` or at or above `WIN_BASE + 4*MEM_WORDS` produces, in its data phase, one cycle with `ready_o`=0 and `resp_o`=1, followed by one cycle with `ready_o`=1 and `resp_o`=1.
- R3: A write beat to storage words `RO_FIRST`..`RO_LAST` (byte offsets 0x30..0x3F with the default parameters) gets the same two-cycle ERROR. Those words are never modified.
- R4: IDLE (2'b00) and BUSY (2'b01) beats get a zero-wait OKAY and neither read nor write storage. During a burst this holds even when a BUSY beat is followed by write data.
- R5: A legal write updates only the byte lanes selected by `size_i` (0 byte, 1 halfword, 2 word) and by `addr_i[1:0]`, aligned down to the size. A legal read returns the full word in its data phase with `resp_o`=0 and `ready_o`=1. Read data is 0 in any other data phase.
- R6: For SEQ beats, the direction and size captured on the burst's NONSEQ beat are used, whatever `write_i` and `size_i` show.
- R7: After a beat of a burst draws an ERROR, the remaining SEQ beats of that burst get a zero-wait OKAY and access nothing. The next NONSEQ is served normally.
- R8: An IDLE or NONSEQ beat in place of an expected SEQ ends the current burst with no error. A new NONSEQ in a different direction is served normally.
- R9: A beat presented while `ready_o` is 0 is not taken. It is taken in the following ready cycle, and its data phase comes after that.
- R10: While `sel_i` is 0, the beat on the bus is not taken, storage is untouched, and any burst in progress is dropped.
- R11: A fixed-length burst (`burst_i` 3'b000 single, 3'b010/011 four beats, 3'b100/101 eight beats, 3'b110/111 sixteen beats; 3'b001 is open-ended) ends after its beat count. Further SEQ beats get a zero-wait OKAY and access nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Slave select for the current address phase |
| addr_i | input | ADDR_W | Byte address of the current address phase |
| trans_i | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| write_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 3 | Transfer size as log2 of the byte count |
| burst_i | input | 3 | Burst type (encoding in R11) |
| wdata_i | input | DATA_W | Write data for the current data phase |
| rdata_o | output | DATA_W | Read data for the current data phase |
| ready_o | output | 1 | Transfer done / bus ready; low only in the first ERROR cycle |
| resp_o | output | 1 | 0 OKAY, 1 ERROR |

## Verification
The bench drives a burst whose second beat hits read-only storage and then keeps issuing SEQ beats. A slave that forgets the failed burst would raise a second ERROR, with ready low again, instead of the expected zero-wait OKAY. It drives a BUSY beat inside a burst with junk write data on the bus, and a SEQ beat with `write_i` flipped low. A design that takes data on BUSY, or that follows the per-beat control lines, leaves the wrong value behind, and the read-back shows it. It also holds a new write through the low-ready error cycle, runs a SEQ beat past the end of a single-beat burst, and applies reset in the middle of an ERROR. A slave that takes the held beat twice, overruns the burst count, or keeps its error state through reset shows it in the read data or in the response.

// File: rtl/ahb_err_pkg.sv
package ahb_err_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  typedef enum logic [1:0] {
    RS_OK       = 2'b00,
    RS_ERR_WAIT = 2'b01,
    RS_ERR_DONE = 2'b10
  } rsp_state_e;

  localparam logic RESP_OKAY  = 1'b0;
  localparam logic RESP_ERROR = 1'b1;

  // Beat count of a burst type; 0 marks an open-ended burst.
  function automatic logic [4:0] burst_beats(input logic [2:0] kind);
    case (kind)
      3'b000:          burst_beats = 5'd1;
      3'b001:          burst_beats = 5'd0;
      3'b010, 3'b011:  burst_beats = 5'd4;
      3'b100, 3'b101:  burst_beats = 5'd8;
      default:         burst_beats = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/ahb_err_burst_track.sv
module ahb_err_burst_track
  import ahb_err_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       take_i,
  input  logic       free_i,
  input  logic [1:0] trans_i,
  input  logic       write_i,
  input  logic [2:0] size_i,
  input  logic [2:0] burst_i,
  input  logic       beat_err_i,
  output logic       live_o,
  output logic       eff_write_o,
  output logic [2:0] eff_size_o
);

  logic       active_q;
  logic       failed_q;
  logic       open_q;
  logic [3:0] left_q;
  logic       lat_write_q;
  logic [2:0] lat_size_q;
  logic       is_ns;
  logic       is_seq;
  logic       seq_ok;
  logic [4:0] beats;

  assign is_ns  = (trans_i == TR_NONSEQ);
  assign is_seq = (trans_i == TR_SEQ);
  assign beats  = burst_beats(burst_i);
  assign seq_ok = is_seq && active_q && !failed_q && (open_q || (left_q != 4'd0));
  assign live_o = take_i && (is_ns || seq_ok);

  assign eff_write_o = is_ns ? write_i : lat_write_q;
  assign eff_size_o  = is_ns ? size_i  : lat_size_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      failed_q    <= 1'b0;
      open_q      <= 1'b0;
      left_q      <= '0;
      lat_write_q <= 1'b0;
      lat_size_q  <= '0;
    end else if (free_i) begin
      active_q <= 1'b0;
    end else if (take_i) begin
      unique case (trans_i)
        TR_NONSEQ: begin
          active_q    <= 1'b1;
          failed_q    <= beat_err_i;
          lat_write_q <= write_i;
          lat_size_q  <= size_i;
          open_q      <= (beats == 5'd0);
          left_q      <= 4'(beats - 5'd1);
        end
        TR_SEQ: begin
          if (seq_ok) begin
            failed_q <= beat_err_i;
            if (!open_q) left_q <= left_q - 4'd1;
          end
        end
        TR_IDLE: active_q <= 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ahb_err_addr_check.sv
module ahb_err_addr_check #(
  parameter int              ADDR_W    = 12,
  parameter int              MEM_WORDS = 16,
  parameter int              LANE_BITS = 2,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h100,
  parameter int              RO_FIRST  = 12,
  parameter int              RO_LAST   = 15,
  localparam int             IDX_W     = $clog2(MEM_WORDS),
  localparam int             WIN_BYTES = MEM_WORDS << LANE_BITS
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  output logic              err_o,
  output logic [IDX_W-1:0]  idx_o
);

  logic [ADDR_W:0] off;
  logic            in_win;
  logic            ro_hit;

  assign off    = {1'b0, addr_i} - {1'b0, WIN_BASE};
  assign in_win = (addr_i >= WIN_BASE) && (off < (ADDR_W+1)'(WIN_BYTES));
  assign idx_o  = off[LANE_BITS +: IDX_W];
  assign ro_hit = (idx_o >= IDX_W'(RO_FIRST)) && (idx_o <= IDX_W'(RO_LAST));
  assign err_o  = in_win ? (write_i && ro_hit) : 1'b1;

endmodule

// File: rtl/ahb_err_resp_fsm.sv
module ahb_err_resp_fsm
  import ahb_err_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  output logic ready_o,
  output logic resp_o
);

  rsp_state_e state_q, state_d;

  always_comb begin
    unique case (state_q)
      RS_OK:       state_d = flag_i ? RS_ERR_WAIT : RS_OK;
      RS_ERR_WAIT: state_d = RS_ERR_DONE;
      RS_ERR_DONE: state_d = flag_i ? RS_ERR_WAIT : RS_OK;
      default:     state_d = RS_OK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RS_OK;
    else         state_q <= state_d;
  end

  assign ready_o = (state_q != RS_ERR_WAIT);
  assign resp_o  = (state_q == RS_OK) ? RESP_OKAY : RESP_ERROR;

endmodule

// File: rtl/ahb_err_store.sv
module ahb_err_store #(
  parameter int  WORDS  = 16,
  parameter int  DATA_W = 32,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [STRB_W-1:0] be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] store_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WORDS; w++) store_q[w] <= '0;
    end else if (we_i) begin
      for (int b = 0; b < STRB_W; b++)
        if (be_i[b]) store_q[idx_i][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  assign rdata_o = store_q[idx_i];

endmodule

// File: rtl/ahb_err_slave.sv
module ahb_err_slave
  import ahb_err_pkg::*;
#(
  parameter int              ADDR_W    = 12,
  parameter int              DATA_W    = 32,
  parameter int              MEM_WORDS = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 'h100,
  parameter int              RO_FIRST  = 12,
  parameter int              RO_LAST   = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        trans_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic [2:0]        burst_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              resp_o
);

  localparam int STRB_W    = DATA_W / 8;
  localparam int LANE_BITS = $clog2(STRB_W);
  localparam int IDX_W     = $clog2(MEM_WORDS);

  function automatic logic [STRB_W-1:0] lane_mask(input logic [2:0] sz,
                                                  input logic [LANE_BITS-1:0] lo);
    int nb;
    int al;
    logic [STRB_W-1:0] m;
    nb = (int'(sz) > LANE_BITS) ? STRB_W : (1 << sz);
    al = int'(lo) & ~(nb - 1);
    for (int b = 0; b < STRB_W; b++) m[b] = (b >= al) && (b < al + nb);
    return m;
  endfunction

  logic              take, free;
  logic              live, eff_write, chk_err, new_err;
  logic [2:0]        eff_size;
  logic [IDX_W-1:0]  idx;
  logic              dp_live_q, dp_write_q;
  logic [IDX_W-1:0]  dp_idx_q;
  logic [STRB_W-1:0] dp_be_q;
  logic              mem_we;
  logic [DATA_W-1:0] mem_rd;

  assign take    = sel_i && ready_o;
  assign free    = !sel_i && ready_o;
  assign new_err = live && chk_err;

  ahb_err_burst_track u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .free_i     (free),
    .trans_i    (trans_i),
    .write_i    (write_i),
    .size_i     (size_i),
    .burst_i    (burst_i),
    .beat_err_i (chk_err),
    .live_o     (live),
    .eff_write_o(eff_write),
    .eff_size_o (eff_size)
  );

  ahb_err_addr_check #(
    .ADDR_W   (ADDR_W),
    .MEM_WORDS(MEM_WORDS),
    .LANE_BITS(LANE_BITS),
    .WIN_BASE (WIN_BASE),
    .RO_FIRST (RO_FIRST),
    .RO_LAST  (RO_LAST)
  ) u_check (
    .addr_i (addr_i),
    .write_i(eff_write),
    .err_o  (chk_err),
    .idx_o  (idx)
  );

  ahb_err_resp_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (new_err),
    .ready_o(ready_o),
    .resp_o (resp_o)
  );

  // Data-phase capture: only advances while the bus is ready.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dp_live_q  <= 1'b0;
      dp_write_q <= 1'b0;
      dp_idx_q   <= '0;
      dp_be_q    <= '0;
    end else if (ready_o) begin
      dp_live_q  <= live && !chk_err;
      dp_write_q <= eff_write;
      dp_idx_q   <= idx;
      dp_be_q    <= lane_mask(eff_size, addr_i[LANE_BITS-1:0]);
    end
  end

  assign mem_we = dp_live_q && dp_write_q;

  ahb_err_store #(
    .WORDS (MEM_WORDS),
    .DATA_W(DATA_W)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_we),
    .idx_i  (dp_idx_q),
    .be_i   (dp_be_q),
    .wdata_i(wdata_i),
    .rdata_o(mem_rd)
  );

  assign rdata_o = (dp_live_q && !dp_write_q) ? mem_rd : '0;

endmodule

// File: rtl/ahb_err_slave_chk.sv
module ahb_err_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sel_i,
  input logic [1:0] trans_i,
  input logic       ready_o,
  input logic       resp_o,
  input logic       mem_we
);

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (ready_o && !resp_o)); // R1

  AST_LOW_MEANS_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> resp_o); // R2

  AST_ERR_SECOND_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> (ready_o && resp_o)); // R2

  AST_ERR_HAS_FIRST_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && resp_o) |-> $past(!ready_o)); // R2

  AST_NO_WRITE_ON_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_o |-> !mem_we); // R3

  AST_IDLE_BUSY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && ready_o && !trans_i[1]) |=> !mem_we); // R4

  AST_NO_DATA_AFTER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> !mem_we); // R9

endmodule

bind ahb_err_slave ahb_err_slave_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sel_i  (sel_i),
  .trans_i(trans_i),
  .ready_o(ready_o),
  .resp_o (resp_o),
  .mem_we (mem_we)
);

// File: tb/ahb_err_slave_test.sv
module ahb_err_slave_test;

  typedef struct packed {
    logic        sel;
    logic [1:0]  tr;
    logic        wr;
    logic [2:0]  sz;
    logic [2:0]  bu;
    logic [11:0] ad;
    logic [31:0] wd;
    logic        rdy;
    logic        rsp;
    logic        ck;
    logic [31:0] rd;
    logic [7:0]  req;
  } row_t;

  localparam logic [1:0] I = 2'b00, B = 2'b01, N = 2'b10, S = 2'b11;
  localparam int NROWS = 61;

  // Each row: address-phase inputs plus write data of the current data phase,
  // then the ready/response/read data expected in that same cycle.
  localparam row_t TBL [NROWS] = '{
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd4},  // R4
    '{1'b1, N, 1'b1, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd5},  // R5
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'hA5A50001, 1'b1, 1'b0, 1'b0, 32'h0,        8'd5},
    '{1'b1, N, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd5},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b1, 32'hA5A50001, 8'd5},
    '{1'b1, N, 1'b1, 3'd0, 3'd0, 12'h102, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd5},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h11CC2233, 1'b1, 1'b0, 1'b0, 32'h0,        8'd5},
    '{1'b1, N, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd5},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b1, 32'hA5CC0001, 8'd5},
    '{1'b1, N, 1'b1, 3'd2, 3'd0, 12'h200, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd2},  // R2
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b0, 32'h0,        8'd2},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b1, 1'b0, 32'h0,        8'd2},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd2},
    '{1'b1, N, 1'b1, 3'd2, 3'd0, 12'h130, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd3},  // R3
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h77777777, 1'b0, 1'b1, 1'b0, 32'h0,        8'd3},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b1, 1'b0, 32'h0,        8'd3},
    '{1'b1, N, 1'b0, 3'd2, 3'd0, 12'h130, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd3},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b1, 32'h0,        8'd3},
    '{1'b1, N, 1'b1, 3'd2, 3'd1, 12'h12C, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd7},  // R7
    '{1'b1, S, 1'b1, 3'd2, 3'd1, 12'h130, 32'h11111111, 1'b1, 1'b0, 1'b0, 32'h0,        8'd7},
    '{1'b1, S, 1'b1, 3'd2, 3'd1, 12'h134, 32'h22222222, 1'b0, 1'b1, 1'b0, 32'h0,        8'd7},
    '{1'b1, S, 1'b1, 3'd2, 3'd1, 12'h134, 32'h22222222, 1'b1, 1'b1, 1'b0, 32'h0,        8'd7},
    '{1'b1, S, 1'b1, 3'd2, 3'd1, 12'h138, 32'h33333333, 1'b1, 1'b0, 1'b0, 32'h0,        8'd7},
    '{1'b1, N, 1'b0, 3'd2, 3'd0, 12'h12C, 32'h44444444, 1'b1, 1'b0, 1'b0, 32'h0,        8'd7},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b1, 32'h11111111, 8'd7},
    '{1'b1, N, 1'b1, 3'd2, 3'd1, 12'h104, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd6},  // R6
    '{1'b1, S, 1'b0, 3'd2, 3'd1, 12'h108, 32'hB0000001, 1'b1, 1'b0, 1'b0, 32'h0,        8'd6},
    '{1'b1, B, 1'b0, 3'd2, 3'd1, 12'h10C, 32'hB0000002, 1'b1, 1'b0, 1'b0, 32'h0,        8'd4},
    '{1'b1, S, 1'b0, 3'd2, 3'd1, 12'h10C, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 32'h0,        8'd4},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'hB0000003, 1'b1, 1'b0, 1'b0, 32'h0,        8'd6},
    '{1'b1, N, 1'b0, 3'd2, 3'd0, 12'h108, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd6},
    '{1'b1, N, 1'b0, 3'd2, 3'd0, 12'h10C, 32'h0,        1'b1, 1'b0, 1'b1, 32'hB0000002, 8'd6},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b1, 32'hB0000003, 8'd4},
    '{1'b1, N, 1'b1, 3'd2, 3'd3, 12'h110, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd8},  // R8
    '{1'b1, N, 1'b0, 3'd2, 3'd1, 12'h104, 32'hC0000010, 1'b1, 1'b0, 1'b0, 32'h0,        8'd8},
    '{1'b1, S, 1'b0, 3'd2, 3'd1, 12'h108, 32'h0,        1'b1, 1'b0, 1'b1, 32'hB0000001, 8'd8},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b1, 32'hB0000002, 8'd8},
    '{1'b1, N, 1'b0, 3'd2, 3'd0, 12'h110, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd8},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b1, 32'hC0000010, 8'd8},
    '{1'b0, N, 1'b1, 3'd2, 3'd0, 12'h110, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd10}, // R10
    '{1'b1, N, 1'b0, 3'd2, 3'd0, 12'h110, 32'hDEADBEEF, 1'b1, 1'b0, 1'b1, 32'h0,        8'd10},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b1, 32'hC0000010, 8'd10},
    '{1'b1, N, 1'b1, 3'd2, 3'd0, 12'h000, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd9},  // R9
    '{1'b1, N, 1'b1, 3'd2, 3'd0, 12'h114, 32'h0,        1'b0, 1'b1, 1'b0, 32'h0,        8'd9},
    '{1'b1, N, 1'b1, 3'd2, 3'd0, 12'h114, 32'h0,        1'b1, 1'b1, 1'b0, 32'h0,        8'd9},
    '{1'b1, N, 1'b0, 3'd2, 3'd0, 12'h114, 32'hE0000114, 1'b1, 1'b0, 1'b0, 32'h0,        8'd9},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b1, 32'hE0000114, 8'd9},
    '{1'b1, B, 1'b1, 3'd2, 3'd0, 12'h118, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd4},  // R4
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h99999999, 1'b1, 1'b0, 1'b0, 32'h0,        8'd4},
    '{1'b1, N, 1'b0, 3'd2, 3'd0, 12'h118, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd4},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b1, 32'h0,        8'd4},
    '{1'b1, N, 1'b1, 3'd2, 3'd0, 12'h11C, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd11}, // R11
    '{1'b1, S, 1'b1, 3'd2, 3'd0, 12'h120, 32'h00000005, 1'b1, 1'b0, 1'b0, 32'h0,        8'd11},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h00000006, 1'b1, 1'b0, 1'b0, 32'h0,        8'd11},
    '{1'b1, N, 1'b0, 3'd2, 3'd0, 12'h120, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd11},
    '{1'b1, N, 1'b0, 3'd2, 3'd0, 12'h11C, 32'h0,        1'b1, 1'b0, 1'b1, 32'h0,        8'd11},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b1, 32'h00000005, 8'd11},
    '{1'b1, N, 1'b1, 3'd1, 3'd0, 12'h126, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd5},  // R5 halfword
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'hABCD1234, 1'b1, 1'b0, 1'b0, 32'h0,        8'd5},
    '{1'b1, N, 1'b0, 3'd2, 3'd0, 12'h124, 32'h0,        1'b1, 1'b0, 1'b0, 32'h0,        8'd5},
    '{1'b1, I, 1'b0, 3'd2, 3'd0, 12'h100, 32'h0,        1'b1, 1'b0, 1'b1, 32'hABCD0000, 8'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  trans = 2'b00;
  logic        wr = 1'b0;
  logic [2:0]  size = 3'd2;
  logic [2:0]  burst = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready;
  logic        resp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ahb_err_slave uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .sel_i  (sel),
    .addr_i (addr),
    .trans_i(trans),
    .write_i(wr),
    .size_i (size),
    .burst_i(burst),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .ready_o(ready),
    .resp_o (resp)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [1:0] t, input logic w,
                       input logic [2:0] z, input logic [11:0] a, input logic [31:0] d);
    sel = s; trans = t; wr = w; size = z; burst = 3'd0; addr = a; wdata = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 32'(ready), 32'd1);
    check("R1 resp in reset", 32'(resp), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 ready after reset", 32'(ready), 32'd1);
    check("R1 rdata after reset", rdata, 32'h0);

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      sel = TBL[i].sel; trans = TBL[i].tr; wr = TBL[i].wr; size = TBL[i].sz;
      burst = TBL[i].bu; addr = TBL[i].ad; wdata = TBL[i].wd;
      #1;
      check($sformatf("R%0d row %0d ready", TBL[i].req, i), 32'(ready), 32'(TBL[i].rdy));
      check($sformatf("R%0d row %0d resp", TBL[i].req, i), 32'(resp), 32'(TBL[i].rsp));
      if (TBL[i].ck)
        check($sformatf("R%0d row %0d rdata", TBL[i].req, i), rdata, TBL[i].rd);
    end

    // R1: reset applied in the low-ready error cycle clears the response at once
    @(negedge clk);
    drive(1'b1, N, 1'b1, 3'd2, 12'h000, 32'h0);
    @(negedge clk);
    drive(1'b1, I, 1'b0, 3'd2, 12'h100, 32'h0);
    #1;
    check("R2 directed first error cycle", 32'(ready), 32'd0);
    rst_n = 1'b0;
    #1;
    check("R1 ready on reset in error", 32'(ready), 32'd1);
    check("R1 resp on reset in error", 32'(resp), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, N, 1'b0, 3'd2, 12'h100, 32'h0);
    @(negedge clk);
    drive(1'b1, I, 1'b0, 3'd2, 12'h100, 32'h0);
    #1;
    check("R1 storage cleared by reset", rdata, 32'h0);
    check("R1 resp after reset", 32'(resp), 32'd0);

    @(negedge clk);
    finish_run();
  end

endmodule